// File: doc/BRIEF.md
# Link Training Data FIFO

This block is the small data store a graphics DRAM uses while its memory controller calibrates the read and write data eyes. The store never touches the main array. The controller fills it in one of two ways. A load command writes a whole entry at once from a parallel port. A training write captures one serial burst from the data pins, a fixed number of cycles after the command. A training read plays one entry back as a serial burst on the output beat port, a programmable number of cycles after its command.

The block keeps a write pointer and a read pointer between commands. Each pointer steps through the six entries and wraps back to the first one. A read does not consume the entry it sends, so a stored pattern can be played back as many times as needed. A clear input sends both pointers back to entry 0 and leaves the stored data as it is.

The output stream has a valid strobe and no ready signal. The pins cannot stall, so the bench has no way to hold a burst back. Once a burst starts, it runs for all its beats. The write-data stream also has no handshake: its beats are sampled on fixed cycles counted from the command. Issue commands of one kind at least BEATS cycles apart. A burst of BEATS beats then never overlaps the next one.

Top module: `trn_fifo_top`

## Requirements
- R1: After reset, every entry holds all zeros and both pointers are at entry 0. `rd_valid` and `rd_beat` are 0, and a read issued before any fill sends eight zero beats.
- R2: A `cmd_load` pulse writes `ld_data` into the entry at the write pointer and advances the write pointer by one.
- R3: For a `cmd_wr` sampled at clock edge k, the block samples beat i on `wr_beat` at edge k+WL+i, for i = 0..7. The eight beats are stored as one entry at the write pointer, with beat i in bits [32i+31:32i], and the write pointer advances by one.
- R4: For a `cmd_rd` sampled at edge k, `rd_valid` is high for exactly the eight cycles that follow edges k+RL .. k+RL+7. During the cycle after edge k+RL+i, `rd_beat` carries bits [32i+31:32i] of the entry at the read pointer, and the read pointer advances by one.
- R5: Both pointers wrap modulo 6, and reads leave entries unchanged. After six loads, the seventh of seven reads sends entry 0 again.
- R6: A `clear` pulse returns both pointers to entry 0 and leaves the contents of all entries unchanged.
- R7: When `cmd_load` and `cmd_wr` are sampled on the same edge, the load is performed. The training write is dropped: no beats are captured, and the write pointer advances only once.
- R8: RL is `rd_lat` clamped into 6..20, and WL is `wr_lat` clamped into 3..7. For example, a value of 25 acts as 20, 2 acts as 6, and a write latency of 1 acts as 3.
- R9: Reads issued exactly eight cycles apart produce back-to-back bursts, with `rd_valid` staying high across the boundary between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Returns both pointers to entry 0 |
| rd_lat | input | 5 | Read latency in cycles (clamped to 6..20) |
| wr_lat | input | 3 | Write capture latency in cycles (clamped to 3..7) |
| cmd_load | input | 1 | Load command: parallel write of `ld_data` |
| ld_data | input | 256 | Entry value for the load command |
| cmd_wr | input | 1 | Training write command |
| wr_beat | input | 32 | Serial write-data beat |
| cmd_rd | input | 1 | Training read command |
| rd_valid | output | 1 | High while a read burst is on `rd_beat` |
| rd_beat | output | 32 | Serial read-data beat (0 when idle) |

## Verification
A bad pointer shows up only at the next read that uses it: that burst carries another entry's pattern, a full RL cycles after the command. A pointer that has drifted stays wrong until a clear. A latency tap in the wrong place moves a whole burst by whole cycles, so every beat of it arrives at the wrong time. A deserializer fault corrupts or reorders beats inside a single entry, and the bench sees it only when that entry is read back. The bench therefore stores a distinct pattern in every beat of every entry and compares each beat against the exact cycle in which it is expected.

// File: rtl/trn_fifo_pkg.sv
package trn_fifo_pkg;

  function automatic int unsigned wrap_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned clamp_lat(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/trn_cmd_delay.sv
module trn_cmd_delay
  import trn_fifo_pkg::*;
#(
  parameter int MIN_LAT = 6,
  parameter int MAX_LAT = 20,
  parameter int LAT_W   = 5,
  parameter int PL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [PL_W-1:0]  in_pl,
  input  logic [LAT_W-1:0] lat,
  output logic             out_vld,
  output logic [PL_W-1:0]  out_pl
);
  localparam int TAP_W = $clog2(MAX_LAT);

  logic [MAX_LAT-1:0] vld_q;
  logic [PL_W-1:0]    pl_q [MAX_LAT];
  logic [TAP_W-1:0]   tap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < MAX_LAT; i++) pl_q[i] <= '0;
    end else begin
      vld_q    <= {vld_q[MAX_LAT-2:0], in_vld};
      pl_q[0]  <= in_pl;
      for (int i = 1; i < MAX_LAT; i++) pl_q[i] <= pl_q[i-1];
    end
  end

  // stage j holds a command sampled j+1 edges ago; tap the stage one short of the latency
  always_comb begin
    tap_idx = TAP_W'(clamp_lat(int'(lat), MIN_LAT, MAX_LAT) - 1);
  end

  assign out_vld = vld_q[tap_idx];
  assign out_pl  = pl_q[tap_idx];

endmodule

// File: rtl/trn_fifo_store.sv
module trn_fifo_store
  import trn_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ENT_W = 256,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ld_en,
  input  logic [ENT_W-1:0] ld_data,
  input  logic             wr_cmd,
  input  logic             cm_en,
  input  logic [PTR_W-1:0] cm_ptr,
  input  logic [ENT_W-1:0] cm_data,
  input  logic             rd_cmd,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ld_en) mem[wr_ptr] <= ld_data;
      if (cm_en) mem[cm_ptr] <= cm_data;
      if (clear) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (ld_en || wr_cmd) wr_ptr <= PTR_W'(wrap_next(int'(wr_ptr), DEPTH));
        if (rd_cmd)          rd_ptr <= PTR_W'(wrap_next(int'(rd_ptr), DEPTH));
      end
    end
  end

  assign rd_data = mem[rd_idx];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < DEPTH) && (int'(rd_ptr) < DEPTH)); // R5
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !clear && (int'(rd_ptr) == DEPTH-1) |=> (rd_ptr == '0)); // R5
  AST_CLEAR_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (wr_ptr == '0) && (rd_ptr == '0)); // R6

endmodule

// File: rtl/trn_burst_ser.sv
module trn_burst_ser #(
  parameter int DQ_W  = 32,
  parameter int BEATS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DQ_W*BEATS-1:0] ent,
  output logic                  bvalid,
  output logic [DQ_W-1:0]       beat
);
  localparam int ENT_W = DQ_W * BEATS;
  localparam int CNT_W = $clog2(BEATS);

  logic [ENT_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      sh   <= ent;
      cnt  <= CNT_W'(BEATS-1);
      busy <= 1'b1;
    end else if (busy) begin
      sh <= sh >> DQ_W;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign bvalid = busy;
  assign beat   = busy ? sh[DQ_W-1:0] : '0;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) |=> busy); // R4
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt == '0) && !start |=> !busy); // R4

endmodule

// File: rtl/trn_burst_des.sv
module trn_burst_des #(
  parameter int DQ_W  = 32,
  parameter int BEATS = 8,
  parameter int PTR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PTR_W-1:0]      start_ptr,
  input  logic [DQ_W-1:0]       beat,
  output logic                  cm_en,
  output logic [PTR_W-1:0]      cm_ptr,
  output logic [DQ_W*BEATS-1:0] cm_data
);
  localparam int ENT_W = DQ_W * BEATS;
  localparam int CNT_W = $clog2(BEATS);

  logic [ENT_W-DQ_W-1:0] sh;
  logic [ENT_W-1:0]      nxt;
  logic [CNT_W-1:0]      cnt;
  logic                  busy;
  logic [PTR_W-1:0]      ptr;

  // new beats enter at the top, so beat 0 ends up in the lowest slice
  assign nxt = {beat, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      ptr  <= '0;
    end else if (start) begin
      sh   <= nxt[ENT_W-1:DQ_W];
      cnt  <= CNT_W'(1);
      busy <= 1'b1;
      ptr  <= start_ptr;
    end else if (busy) begin
      sh  <= nxt[ENT_W-1:DQ_W];
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(BEATS-1)) busy <= 1'b0;
    end
  end

  assign cm_en   = busy && (cnt == CNT_W'(BEATS-1));
  assign cm_ptr  = ptr;
  assign cm_data = nxt;

  AST_DES_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy || cm_en); // R3

endmodule

// File: rtl/trn_fifo_top.sv
module trn_fifo_top #(
  parameter int DQ_W   = 32,
  parameter int BEATS  = 8,
  parameter int DEPTH  = 6,
  parameter int RL_MIN = 6,
  parameter int RL_MAX = 20,
  parameter int WL_MIN = 3,
  parameter int WL_MAX = 7,
  localparam int ENT_W = DQ_W * BEATS,
  localparam int RL_W  = $clog2(RL_MAX + 1),
  localparam int WL_W  = $clog2(WL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [RL_W-1:0]  rd_lat,
  input  logic [WL_W-1:0]  wr_lat,
  input  logic             cmd_load,
  input  logic [ENT_W-1:0] ld_data,
  input  logic             cmd_wr,
  input  logic [DQ_W-1:0]  wr_beat,
  input  logic             cmd_rd,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_beat
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             wr_acc;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wdly_vld, rdly_vld;
  logic [PTR_W-1:0] wdly_ptr, rdly_ptr;
  logic             cm_en;
  logic [PTR_W-1:0] cm_ptr;
  logic [ENT_W-1:0] cm_data, rd_data;

  // the load owns the write pointer when both arrive together
  assign wr_acc = cmd_wr && !cmd_load;

  trn_cmd_delay #(.MIN_LAT(WL_MIN), .MAX_LAT(WL_MAX), .LAT_W(WL_W), .PL_W(PTR_W)) u_wdly (
    .clk, .rst_n, .in_vld(wr_acc), .in_pl(wr_ptr), .lat(wr_lat),
    .out_vld(wdly_vld), .out_pl(wdly_ptr)
  );

  trn_cmd_delay #(.MIN_LAT(RL_MIN), .MAX_LAT(RL_MAX), .LAT_W(RL_W), .PL_W(PTR_W)) u_rdly (
    .clk, .rst_n, .in_vld(cmd_rd), .in_pl(rd_ptr), .lat(rd_lat),
    .out_vld(rdly_vld), .out_pl(rdly_ptr)
  );

  trn_fifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .PTR_W(PTR_W)) u_store (
    .clk, .rst_n, .clear,
    .ld_en(cmd_load), .ld_data,
    .wr_cmd(wr_acc),
    .cm_en, .cm_ptr, .cm_data,
    .rd_cmd(cmd_rd), .rd_idx(rdly_ptr), .rd_data,
    .wr_ptr, .rd_ptr
  );

  trn_burst_des #(.DQ_W(DQ_W), .BEATS(BEATS), .PTR_W(PTR_W)) u_des (
    .clk, .rst_n, .start(wdly_vld), .start_ptr(wdly_ptr), .beat(wr_beat),
    .cm_en, .cm_ptr, .cm_data
  );

  trn_burst_ser #(.DQ_W(DQ_W), .BEATS(BEATS)) u_ser (
    .clk, .rst_n, .start(rdly_vld), .ent(rd_data),
    .bvalid(rd_valid), .beat(rd_beat)
  );

endmodule

// File: tb/trn_fifo_top_tb_top.sv
module trn_fifo_top_tb_top;
  localparam int DQ_W = 32;
  localparam int NB   = 8;
  localparam int EW   = DQ_W * NB;
  localparam int DEP  = 6;

  typedef struct {
    int          cyc;
    logic [31:0] d;
    string       req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic [4:0]    rd_lat = 5'd6;
  logic [2:0]    wr_lat = 3'd3;
  logic          cmd_load = 1'b0;
  logic [EW-1:0] ld_data = '0;
  logic          cmd_wr = 1'b0;
  logic [31:0]   wr_beat = '0;
  logic          cmd_rd = 1'b0;
  logic          rd_valid;
  logic [31:0]   rd_beat;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 1'b0;
  item_t q[$];
  logic [EW-1:0] exp_mem [DEP];
  int wp = 0, rp = 0;

  trn_fifo_top dut_i (
    .clk, .rst_n, .clear, .rd_lat, .wr_lat, .cmd_load, .ld_data,
    .cmd_wr, .wr_beat, .cmd_rd, .rd_valid, .rd_beat
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampv(int v, int lo, int hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  function automatic logic [EW-1:0] mk(int s);
    logic [EW-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b*32 +: 32] = {8'(s), 8'(b), 16'hC3A5 ^ 16'(s * 37 + b)};
    return r;
  endfunction

  task automatic issue_read(string req);
    int k;
    int rl;
    item_t it;
    @(negedge clk);
    cmd_rd = 1'b1;
    k  = cyc + 1;
    rl = clampv(int'(rd_lat), 6, 20);
    for (int i = 0; i < NB; i++) begin
      it.cyc = k + rl + i;
      it.d   = exp_mem[rp][i*32 +: 32];
      it.req = req;
      q.push_back(it);
    end
    rp = (rp + 1) % DEP;
    @(negedge clk);
    cmd_rd = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_load(logic [EW-1:0] d);
    @(negedge clk);
    cmd_load = 1'b1;
    ld_data  = d;
    exp_mem[wp] = d;
    wp = (wp + 1) % DEP;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  // both_cmds=1 raises cmd_load too; the beats are then driven but must be ignored
  task automatic do_write(logic [EW-1:0] d, bit both_cmds, logic [EW-1:0] ld);
    int k;
    int wl;
    @(negedge clk);
    cmd_wr = 1'b1;
    if (both_cmds) begin
      cmd_load = 1'b1;
      ld_data  = ld;
    end
    k  = cyc + 1;
    wl = clampv(int'(wr_lat), 3, 7);
    @(negedge clk);
    cmd_wr   = 1'b0;
    cmd_load = 1'b0;
    for (int i = 0; i < NB; i++) begin
      while (cyc != k + wl + i - 1) @(negedge clk);
      wr_beat = d[i*32 +: 32];
      @(negedge clk);
    end
    wr_beat = '0;
    exp_mem[wp] = both_cmds ? ld : d;
    wp = (wp + 1) % DEP;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    wp = 0;
    rp = 0;
  endtask

  task automatic drain();
    repeat (32) @(negedge clk);
  endtask

  // monitor: compare every output beat with the scoreboard head, value and cycle
  always @(negedge clk) begin
    item_t it;
    if (rst_n && !done) begin
      if (rd_valid) begin
        nchk++;
        if (q.size() == 0) begin
          nfail++;
          $display("FAIL R4 unexpected beat at cycle %0d: actual %h expected no beat", cyc, rd_beat);
        end else begin
          it = q.pop_front();
          if (it.cyc != cyc || it.d != rd_beat) begin
            nfail++;
            $display("FAIL %s beat: actual %h @%0d expected %h @%0d", it.req, rd_beat, cyc, it.d, it.cyc);
          end
        end
      end else if (q.size() > 0 && q[0].cyc <= cyc) begin
        it = q.pop_front();
        nchk++;
        nfail++;
        $display("FAIL %s missing beat: actual none @%0d expected %h @%0d", it.req, cyc, it.d, it.cyc);
      end
    end
  end

  initial begin
    for (int i = 0; i < DEP; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (rd_valid !== 1'b0 || rd_beat !== 32'h0) begin
      nfail++;
      $display("FAIL R1 reset outputs: actual %b/%h expected 0/0", rd_valid, rd_beat);
    end
    // R1: unwritten entry reads back as zeros
    issue_read("R1");
    drain();
    do_clear();

    // R2 loads, then R5 wrap with seven gapless reads (R9), latency 10 (R4)
    for (int i = 0; i < DEP; i++) do_load(mk(i + 1));
    rd_lat = 5'd10;
    for (int i = 0; i < 7; i++) issue_read(i == 6 ? "R5" : "R9");
    drain();

    // R6: clear returns read pointer to 0, contents kept
    do_clear();
    issue_read("R6");
    drain();

    // R3: training writes at two latencies, read back at latency 20 (R4)
    do_clear();
    wr_lat = 3'd3;
    do_write(mk(20), 1'b0, '0);
    wr_lat = 3'd7;
    do_write(mk(21), 1'b0, '0);
    rd_lat = 5'd20;
    issue_read("R3");
    issue_read("R3");
    drain();

    // R7: simultaneous load and training write, then a second load
    do_clear();
    wr_lat = 3'd4;
    do_write(mk(99), 1'b1, mk(30));
    do_load(mk(31));
    drain();
    rp = 0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    wp = 0;
    rd_lat = 5'd6;
    issue_read("R7");
    issue_read("R7");
    issue_read("R7");
    drain();

    // R8: latency clamping on both paths
    do_clear();
    wr_lat = 3'd1;
    do_write(mk(40), 1'b0, '0);
    rd_lat = 5'd25;
    issue_read("R8");
    drain();
    rd_lat = 5'd2;
    issue_read("R8");
    drain();

    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R4 leftover beats: actual %0d expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule